// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block owns the two architectural registers that govern a small processor's floating-point unit. The first is a control register, whose two lowest bits choose the rounding direction used by every arithmetic unit. The second is a status register, which exposes five sticky exception flags. The core writes either register through a single write port. It reads either one back through a combinational read port. The current rounding direction is driven continuously to the datapaths.

Each cycle the arithmetic units report any exceptions they raised on a five-bit flag bus. The unit ORs those bits into a sticky set that only a status write can clear. Some bits of each register are defined as must-be-zero. When a write puts a one into such a bit, the unit raises a single-cycle error pulse, and the offending bits are still discarded.

A parameter selects a legacy variant. In that variant a control write also keeps the upper control field, and control writes never raise the error.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset both registers read as zero, the rounding output is 0 (nearest-even), and the error output is low.
- R2: In the standard variant a control write stores only data bits 6:0. Bits 1:0 hold the rounding code, and the five per-exception fields start at bit 2. Every other bit reads back as zero.
- R3: The rounding output equals control bits 1:0, with this encoding: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. It changes only in the cycle after a control write.
- R4: In the standard variant, a control write with any one in bits 31:12 raises the error output for exactly the following cycle. Ones in bits 11:7 are dropped without an error.
- R5: A status write stores only data bits 11:7 as the sticky flag set. A status read returns that set in bits 11:7, with all other bits zero.
- R6: A status write with any one in bits 31:12 raises the error output for exactly the following cycle, in both variants.
- R7: Flag bits reported by the arithmetic units are ORed into the sticky set one cycle later. The flag order is bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. Flag bit k appears at status bit k+7.
- R8: When a status write and reported unit flags fall in the same cycle, the written value replaces the set and those unit flags are lost.
- R9: Sticky flags remain set after the unit flag bus returns to zero, until a status write changes them.
- R10: In the legacy variant a control write keeps data bits 31:12 and 6:0 (mask 0xFFFFF07F) and never raises the error output.
- R11: Two back-to-back offending writes produce two consecutive error cycles, and the error output drops in the cycle after the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 status |
| rd_data | output | 32 | Combinational read data |
| unit_flags | input | 5 | Exception flags raised this cycle by the arithmetic units |
| round_mode | output | 2 | Current rounding direction code |
| mbz_err | output | 1 | One-cycle pulse after a write that set must-be-zero bits |

## Verification
The bench writes all-ones to each register. A design that masked wrongly would leak bits 11:7 into the control register, keep control bits in the status register, or lose the upper field in the legacy instance. It writes ones only into the silently dropped control bits 11:7, where a design that checked too wide a range would pulse a spurious error. It collides a status write with unit flags in the same cycle, where a design that gave the OR priority would leave extra flags set. It also walks single flags in one at a time to catch a scrambled bit order, and sends two offending writes back to back, where a stretched or merged pulse would show as a wrong error length.

// File: rtl/fpcsr_pkg.sv
`timescale 1ns/1ps
package fpcsr_pkg;
    // number of sticky exception flags
    localparam int unsigned FLAG_W       = 5;
    // status register bit where flag 0 sits
    localparam int unsigned FLAG_LSB     = 7;
    // highest control bit kept in the standard variant
    localparam int unsigned CTRL_KEEP_HI = 6;
    // lowest must-be-zero bit in both registers
    localparam int unsigned MBZ_LSB      = 12;
    // width of the rounding code
    localparam int unsigned RND_W        = 2;

    // flag positions within the flag vector
    localparam int unsigned FLG_INEXACT   = 0;
    localparam int unsigned FLG_UNDERFLOW = 1;
    localparam int unsigned FLG_OVERFLOW  = 2;
    localparam int unsigned FLG_DIVZERO   = 3;
    localparam int unsigned FLG_INVALID   = 4;

    typedef enum logic [RND_W-1:0] {
        RND_NEAREST_EVEN = 2'd0,
        RND_TOWARD_ZERO  = 2'd1,
        RND_TOWARD_POS   = 2'd2,
        RND_TOWARD_NEG   = 2'd3
    } round_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } csr_sel_e;
endpackage

// File: rtl/fpcsr_ctrl.sv
`timescale 1ns/1ps
module fpcsr_ctrl
    import fpcsr_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned LEGACY = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [XLEN-1:0]      wr_data,
    output logic [XLEN-1:0]      ctrl_q,
    output logic [RND_W-1:0]     round_mode,
    output logic                 mbz_hit
);
    localparam logic [XLEN-1:0] LOW_KEEP   =
        {{(XLEN-CTRL_KEEP_HI-1){1'b0}}, {(CTRL_KEEP_HI+1){1'b1}}};
    localparam logic [XLEN-1:0] HIGH_FIELD =
        {{(XLEN-MBZ_LSB){1'b1}}, {MBZ_LSB{1'b0}}};
    localparam logic [XLEN-1:0] KEEP_MASK  =
        (LEGACY != 0) ? (LOW_KEEP | HIGH_FIELD) : LOW_KEEP;

    typedef struct packed {
        logic [XLEN-1:0] value;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.value = wr_data & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q     = st_q.value;
    assign round_mode = st_q.value[RND_W-1:0];

    generate
        if (LEGACY != 0) begin : g_legacy
            assign mbz_hit = 1'b0;
        end else begin : g_std
            assign mbz_hit = wr_ctrl && (|(wr_data & HIGH_FIELD));
        end
    endgenerate

    // R2
    ctrl_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl_q[CTRL_KEEP_HI:0] == $past(wr_data[CTRL_KEEP_HI:0]));

    // R3
    round_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(round_mode));
endmodule

// File: rtl/fpcsr_sticky.sv
`timescale 1ns/1ps
module fpcsr_sticky
    import fpcsr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [FLAG_W-1:0] unit_flags,
    output logic [FLAG_W-1:0] flags_q,
    output logic              mbz_hit
);
    localparam int unsigned FLAG_HI = FLAG_LSB + FLAG_W - 1;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } sticky_state_t;

    sticky_state_t st_d, st_q;
    logic          unused_low_bits;

    assign unused_low_bits = ^wr_data[FLAG_LSB-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_stat) begin
            st_d.flags = wr_data[FLAG_HI:FLAG_LSB];
        end else begin
            st_d.flags = st_q.flags | unit_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
    assign mbz_hit = wr_stat && (|wr_data[XLEN-1:MBZ_LSB]);

    // R7
    flags_accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (flags_q & $past(unit_flags)) == $past(unit_flags));

    // R9
    flags_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (flags_q & $past(flags_q)) == $past(flags_q));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> flags_q == $past(wr_data[FLAG_HI:FLAG_LSB]));
endmodule

// File: rtl/fpcsr_errpulse.sv
`timescale 1ns/1ps
module fpcsr_errpulse #(
    parameter int unsigned N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hit,
    output logic             err
);
    typedef struct packed {
        logic pulse;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = |hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.pulse;

    // R11
    pulse_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(|hit));
endmodule

// File: rtl/fpcsr_readmux.sv
`timescale 1ns/1ps
module fpcsr_readmux
    import fpcsr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              rd_sel,
    input  logic [XLEN-1:0]   ctrl_q,
    input  logic [FLAG_W-1:0] flags_q,
    output logic [XLEN-1:0]   rd_data
);
    logic [XLEN-1:0] stat_view;

    always_comb begin
        stat_view = '0;
        stat_view[FLAG_LSB +: FLAG_W] = flags_q;
    end

    always_comb begin
        if (csr_sel_e'(rd_sel) == SEL_STAT) begin
            rd_data = stat_view;
        end else begin
            rd_data = ctrl_q;
        end
    end
endmodule

// File: rtl/fpcsr_unit.sv
`timescale 1ns/1ps
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned LEGACY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              rd_sel,
    output logic [XLEN-1:0]   rd_data,
    input  logic [FLAG_W-1:0] unit_flags,
    output logic [RND_W-1:0]  round_mode,
    output logic              mbz_err
);
    logic              wr_ctrl;
    logic              wr_stat;
    logic [XLEN-1:0]   ctrl_q;
    logic [FLAG_W-1:0] flags_q;
    logic              ctrl_hit;
    logic              stat_hit;

    assign wr_ctrl = wr_en && (csr_sel_e'(wr_sel) == SEL_CTRL);
    assign wr_stat = wr_en && (csr_sel_e'(wr_sel) == SEL_STAT);

    fpcsr_ctrl #(.XLEN(XLEN), .LEGACY(LEGACY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_q),
        .round_mode (round_mode),
        .mbz_hit    (ctrl_hit)
    );

    fpcsr_sticky #(.XLEN(XLEN)) u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_stat),
        .wr_data    (wr_data),
        .unit_flags (unit_flags),
        .flags_q    (flags_q),
        .mbz_hit    (stat_hit)
    );

    fpcsr_errpulse #(.N_SRC(2)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   ({stat_hit, ctrl_hit}),
        .err   (mbz_err)
    );

    fpcsr_readmux #(.XLEN(XLEN)) u_rd (
        .rd_sel  (rd_sel),
        .ctrl_q  (ctrl_q),
        .flags_q (flags_q),
        .rd_data (rd_data)
    );

    // R4 R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mbz_err |-> $past(wr_en && (wr_data[XLEN-1:MBZ_LSB] != '0)));

    generate
        if (LEGACY != 0) begin : g_legacy_chk
            // R10
            legacy_ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mbz_err |-> $past(wr_sel == 1'b1));
        end
    endgenerate
endmodule

// File: tb/fpcsr_unit_bench.sv
`timescale 1ns/1ps
module fpcsr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [4:0]  unit_flags = '0;
    logic [31:0] rd_s, rd_l;
    logic [1:0]  rnd_s, rnd_l;
    logic        err_s, err_l;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fpcsr_unit #(.XLEN(32), .LEGACY(0)) u_fpcsr_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_s),
        .unit_flags(unit_flags), .round_mode(rnd_s), .mbz_err(err_s)
    );

    fpcsr_unit #(.XLEN(32), .LEGACY(1)) u_fpcsr_unit_legacy (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_l),
        .unit_flags(unit_flags), .round_mode(rnd_l), .mbz_err(err_l)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one-cycle write; returns at the next negedge, after the register edge
    task automatic do_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_both(input logic sel, output logic [31:0] s, output logic [31:0] l);
        rd_sel = sel;
        #1;
        s = rd_s; l = rd_l;
    endtask

    task automatic t_reset;
        logic [31:0] s, l;
        read_both(1'b0, s, l);
        check("R1 ctrl after reset", s, 32'h0);
        read_both(1'b1, s, l);
        check("R1 status after reset", s, 32'h0);
        check("R1 round after reset", {30'b0, rnd_s}, 32'h0);
        check("R1 err after reset", {31'b0, err_s}, 32'h0);
    endtask

    task automatic t_ctrl_all_ones;
        logic [31:0] s, l;
        do_write(1'b0, 32'hFFFF_FFFF);
        check("R4 err std after ctrl mbz", {31'b0, err_s}, 32'h1);
        check("R10 err legacy after ctrl", {31'b0, err_l}, 32'h0);
        read_both(1'b0, s, l);
        check("R2 ctrl std mask", s, 32'h0000_007F);
        check("R10 ctrl legacy mask", l, 32'hFFFF_F07F);
        check("R3 round code 3", {30'b0, rnd_s}, 32'h3);
        @(negedge clk);
        check("R4 err pulse one cycle", {31'b0, err_s}, 32'h0);
    endtask

    task automatic t_ctrl_dropped_bits;
        logic [31:0] s, l;
        do_write(1'b0, 32'h0000_0F81);
        check("R4 no err for bits 11:7", {31'b0, err_s}, 32'h0);
        read_both(1'b0, s, l);
        check("R2 bits 11:7 dropped", s, 32'h0000_0001);
        check("R10 legacy bits 11:7 dropped", l, 32'h0000_0001);
        check("R3 round toward zero", {30'b0, rnd_s}, 32'h1);
        do_write(1'b0, 32'h0000_007E);
        check("R3 round toward +inf", {30'b0, rnd_s}, 32'h2);
        do_write(1'b0, 32'h0000_0000);
        check("R3 round nearest", {30'b0, rnd_s}, 32'h0);
    endtask

    task automatic t_round_hold;
        // R3: a status write leaves the rounding code alone
        do_write(1'b0, 32'h0000_0003);
        do_write(1'b1, 32'h0000_0000);
        check("R3 round kept over status write", {30'b0, rnd_s}, 32'h3);
    endtask

    task automatic t_status_write;
        logic [31:0] s, l;
        do_write(1'b1, 32'hFFFF_FFFF);
        check("R6 err std after status mbz", {31'b0, err_s}, 32'h1);
        check("R6 err legacy after status mbz", {31'b0, err_l}, 32'h1);
        read_both(1'b1, s, l);
        check("R5 status keeps 11:7", s, 32'h0000_0F80);
        do_write(1'b1, 32'h0000_107F);
        check("R6 err bit 12", {31'b0, err_s}, 32'h1);
        read_both(1'b1, s, l);
        check("R5 status low bits dropped", s, 32'h0);
    endtask

    task automatic t_flag_order;
        logic [31:0] s, l;
        for (int k = 0; k < 5; k++) begin
            do_write(1'b1, 32'h0);
            @(negedge clk);
            unit_flags = 5'(1 << k);
            @(negedge clk);
            unit_flags = '0;
            read_both(1'b1, s, l);
            check("R7 single flag position", s, 32'(1) << (k + 7));
        end
        do_write(1'b1, 32'h0);
        @(negedge clk);
        unit_flags = 5'b00001;
        @(negedge clk);
        unit_flags = 5'b10000;
        @(negedge clk);
        unit_flags = '0;
        repeat (3) @(negedge clk);
        read_both(1'b1, s, l);
        check("R9 flags sticky and ORed", s, 32'h0000_0880);
    endtask

    task automatic t_collision;
        logic [31:0] s, l;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0000_0100;
        unit_flags = 5'b00100;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; unit_flags = '0;
        read_both(1'b1, s, l);
        check("R8 status write wins", s, 32'h0000_0100);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_1000;
        @(negedge clk);
        check("R11 first err cycle", {31'b0, err_s}, 32'h1);
        wr_sel = 1'b1; wr_data = 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check("R11 second err cycle", {31'b0, err_s}, 32'h1);
        @(negedge clk);
        check("R11 err drops", {31'b0, err_s}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_all_ones();
        t_ctrl_dropped_bits();
        t_round_hold();
        t_status_write();
        t_flag_order();
        t_collision();
        t_back_to_back();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule